// File: doc/BRIEF.md
# Serial Wiper Step Controller

This block runs the fine-adjust mode of a multi-channel digital potentiometer controller. The serial front end decodes a step command byte, acknowledges it, and then raises a one-cycle go pulse that carries the channel index. From then on every rising edge of the synchronised serial clock moves that channel's wiper position by one tap. The synchronised serial data level at that edge sets the direction: high counts up towards the high terminal, low counts down towards the low terminal. No byte framing and no acknowledge bits appear between steps, and up and down steps may be mixed in any order and in any number. A stop or a start condition on the bus ends the mode.

The controller has two states. `ST_IDLE` waits for a go pulse, and its transition *enter* leads to `ST_STEP`. In `ST_STEP`, the transition *step* stays in the state and issues a strobe. The transition *retarget* also stays in the state and loads a new channel. The transition *exit* returns to `ST_IDLE` on a start or stop event. A registered up or down strobe goes out together with the channel it applies to. A bank of saturating per-channel wiper registers consumes the strobes, and every channel's wiper value is brought out.

Top module: `wiper_stepper`

## Requirements
- R1: After reset the mode flag is low, both strobes are low, the strobe channel is 0, and every wiper register holds RESET_POS (default 0x80).
- R2: A go pulse in `ST_IDLE` with no start or stop in the same cycle sets the mode flag high from the next cycle and selects `cmd_chan_i` as the target channel.
- R3: In `ST_STEP`, a clock rise with data high produces a one-cycle `step_up_o` pulse in the next cycle. The target channel's wiper is one higher in the cycle after that.
- R4: In `ST_STEP`, a clock rise with data low produces a one-cycle `step_dn_o` pulse in the next cycle. The target channel's wiper is one lower in the cycle after that.
- R5: In `ST_IDLE`, clock rises produce no strobe and change no wiper.
- R6: A wiper register saturates. An up step at 0xFF leaves it at 0xFF, and a down step at 0x00 leaves it at 0x00.
- R7: A stop event clears the mode flag from the next cycle. Later clock rises step nothing until another go pulse arrives.
- R8: A start event leaves the mode in the same way as a stop event.
- R9: A clock rise in the same cycle as a start or stop event produces no step.
- R10: A step changes only the target channel's wiper. All other channels hold their values.
- R11: A go pulse in `ST_STEP` switches the target to the new channel. A clock rise in that same cycle produces no step.
- R12: Clock rises on consecutive cycles, with no gap and mixed directions, each produce exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_rise_i | input | 1 | One-cycle pulse on a synchronised serial clock rising edge |
| sda_lvl_i | input | 1 | Synchronised serial data level |
| start_det_i | input | 1 | One-cycle pulse on a detected start condition |
| stop_det_i | input | 1 | One-cycle pulse on a detected stop condition |
| cmd_go_i | input | 1 | One-cycle pulse: step command acknowledged |
| cmd_chan_i | input | CH_W | Channel carried with the go pulse |
| step_up_o | output | 1 | Registered up-step strobe |
| step_dn_o | output | 1 | Registered down-step strobe |
| step_chan_o | output | CH_W | Channel the strobes apply to |
| mode_active_o | output | 1 | High while in `ST_STEP` |
| wiper_o | output | NCHAN*WIDTH | All wiper positions, channel i at bits i*WIDTH upward |

## Verification
The hardest cases to reach are the saturation edges, because the wipers start mid-scale and can only be moved one tap per clock rise. The stimulus walks one channel past 0xFF and then past 0x00 with long back-to-back pulse trains. The other hard cases are collisions in a single cycle: a clock rise together with a stop, and a clock rise together with a second go pulse. These are driven on purpose so that the priority of exit and retarget over stepping can be seen at the ports.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_STEP = 1'b1
    } wstep_state_e;
endpackage

// File: rtl/wstep_fsm.sv
module wstep_fsm
    import wstep_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise_i,
    input  logic            sda_lvl_i,
    input  logic            start_det_i,
    input  logic            stop_det_i,
    input  logic            cmd_go_i,
    input  logic [CH_W-1:0] cmd_chan_i,
    output logic            step_up_o,
    output logic            step_dn_o,
    output logic [CH_W-1:0] step_chan_o,
    output logic            mode_active_o
);
    wstep_state_e state_q, state_d;
    logic         leave;
    logic         do_step;

    assign leave   = start_det_i | stop_det_i;
    assign do_step = (state_q == ST_STEP) & scl_rise_i & ~leave & ~cmd_go_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!leave && cmd_go_i) state_d = ST_STEP;
            ST_STEP: if (leave)              state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_up_o   <= 1'b0;
            step_dn_o   <= 1'b0;
            step_chan_o <= '0;
        end else begin
            step_up_o <= do_step &  sda_lvl_i;
            step_dn_o <= do_step & ~sda_lvl_i;
            if (cmd_go_i && !leave) step_chan_o <= cmd_chan_i;
        end
    end

    assign mode_active_o = (state_q == ST_STEP);
endmodule

// File: rtl/wstep_cell.sv
module wstep_cell #(
    parameter int          WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_POS = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [WIDTH-1:0] pos_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pos_o <= RESET_POS;
        else if (inc_i && pos_o != TOP)    pos_o <= pos_o + 1'b1;
        else if (dec_i && pos_o != '0)     pos_o <= pos_o - 1'b1;
    end
endmodule

// File: rtl/wstep_bank.sv
module wstep_bank #(
    parameter int               NCHAN     = 4,
    parameter int               WIDTH     = 8,
    parameter int               CH_W      = 2,
    parameter logic [WIDTH-1:0] RESET_POS = 8'h80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   up_i,
    input  logic                   dn_i,
    input  logic [CH_W-1:0]        chan_i,
    output logic [NCHAN*WIDTH-1:0] wiper_o
);
    for (genvar i = 0; i < NCHAN; i++) begin : g_ch
        logic hit;
        assign hit = (chan_i == CH_W'(i));
        wstep_cell #(.WIDTH(WIDTH), .RESET_POS(RESET_POS)) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (up_i & hit),
            .dec_i (dn_i & hit),
            .pos_o (wiper_o[i*WIDTH +: WIDTH])
        );
    end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
    parameter int               NCHAN     = 4,
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_POS = 8'h80,
    localparam int              CH_W      = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_rise_i,
    input  logic                   sda_lvl_i,
    input  logic                   start_det_i,
    input  logic                   stop_det_i,
    input  logic                   cmd_go_i,
    input  logic [CH_W-1:0]        cmd_chan_i,
    output logic                   step_up_o,
    output logic                   step_dn_o,
    output logic [CH_W-1:0]        step_chan_o,
    output logic                   mode_active_o,
    output logic [NCHAN*WIDTH-1:0] wiper_o
);
    wstep_fsm #(.CH_W(CH_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_rise_i    (scl_rise_i),
        .sda_lvl_i     (sda_lvl_i),
        .start_det_i   (start_det_i),
        .stop_det_i    (stop_det_i),
        .cmd_go_i      (cmd_go_i),
        .cmd_chan_i    (cmd_chan_i),
        .step_up_o     (step_up_o),
        .step_dn_o     (step_dn_o),
        .step_chan_o   (step_chan_o),
        .mode_active_o (mode_active_o)
    );

    wstep_bank #(.NCHAN(NCHAN), .WIDTH(WIDTH), .CH_W(CH_W), .RESET_POS(RESET_POS)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (step_up_o),
        .dn_i    (step_dn_o),
        .chan_i  (step_chan_o),
        .wiper_o (wiper_o)
    );
endmodule

// File: rtl/wstep_chk.sv
module wstep_chk #(
    parameter int NCHAN = 4,
    parameter int WIDTH = 8,
    parameter int CH_W  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_rise_i,
    input logic                   start_det_i,
    input logic                   stop_det_i,
    input logic                   step_up_o,
    input logic                   step_dn_o,
    input logic [CH_W-1:0]        step_chan_o,
    input logic                   mode_active_o,
    input logic [NCHAN*WIDTH-1:0] wiper_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [CH_W-1:0]  chan_d;
    logic [WIDTH-1:0] sel_now, sel_then;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_d <= '0;
        else        chan_d <= step_chan_o;
    end

    assign sel_now  = wiper_o[step_chan_o*WIDTH +: WIDTH];
    assign sel_then = wiper_o[chan_d*WIDTH +: WIDTH];

    assert_one_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up_o && step_dn_o));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up_o || step_dn_o) |-> ($past(mode_active_o) && $past(scl_rise_i)));

    assert_stop_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det_i |=> (!mode_active_o && !step_up_o && !step_dn_o));

    assert_start_leaves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det_i |=> (!mode_active_o && !step_up_o && !step_dn_o));

    assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up_o && sel_now != TOP) |=> (sel_then == WIDTH'($past(sel_now) + 1'b1)));

    assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn_o && sel_now != '0) |=> (sel_then == WIDTH'($past(sel_now) - 1'b1)));

    assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up_o && sel_now == TOP) |=> (sel_then == TOP));

    assert_sat_bot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn_o && sel_now == '0) |=> (sel_then == '0));
endmodule

bind wiper_stepper wstep_chk #(.NCHAN(NCHAN), .WIDTH(WIDTH), .CH_W(CH_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_rise_i    (scl_rise_i),
    .start_det_i   (start_det_i),
    .stop_det_i    (stop_det_i),
    .step_up_o     (step_up_o),
    .step_dn_o     (step_dn_o),
    .step_chan_o   (step_chan_o),
    .mode_active_o (mode_active_o),
    .wiper_o       (wiper_o)
);

// File: tb/wiper_stepper_tb_top.sv
`timescale 1ns/1ps
module wiper_stepper_tb_top;
    localparam int NCH = 4;
    localparam int W   = 8;
    localparam int CW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_rise_i = 1'b0, sda_lvl_i = 1'b0;
    logic            start_det_i = 1'b0, stop_det_i = 1'b0;
    logic            cmd_go_i = 1'b0;
    logic [CW-1:0]   cmd_chan_i = '0;
    logic            step_up_o, step_dn_o, mode_active_o;
    logic [CW-1:0]   step_chan_o;
    logic [NCH*W-1:0] wiper_o;

    always #2.5 clk = ~clk;

    wiper_stepper #(.NCHAN(NCH), .WIDTH(W), .RESET_POS(8'h80)) dut_i (.*);

    int    n_vec = 0, n_bad = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_wip[NCH];
    bit m_active, m_up, m_dn;
    int m_chan;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_wip[i]) m_wip[i] = 128;
            m_active = 0; m_up = 0; m_dn = 0; m_chan = 0;
        end else begin
            bit ex, st;
            if (m_up && m_wip[m_chan] < 255) m_wip[m_chan]++;
            if (m_dn && m_wip[m_chan] > 0)   m_wip[m_chan]--;
            ex = start_det_i || stop_det_i;
            st = m_active && scl_rise_i && !ex && !cmd_go_i;
            m_up = st && sda_lvl_i;
            m_dn = st && !sda_lvl_i;
            if (ex)            m_active = 0;
            else if (cmd_go_i) begin m_active = 1; m_chan = int'(cmd_chan_i); end
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, int'(step_up_o), int'(m_up), "step_up");
            chk(cur_req, int'(step_dn_o), int'(m_dn), "step_dn");
            chk(cur_req, int'(step_chan_o), m_chan, "step_chan");
            chk(cur_req, int'(mode_active_o), int'(m_active), "mode");
            for (int i = 0; i < NCH; i++)
                chk(cur_req, int'(wiper_o[i*W +: W]), m_wip[i], "wiper");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rise(bit d, int gap);
        @(negedge clk); scl_rise_i = 1; sda_lvl_i = d;
        @(negedge clk); scl_rise_i = 0;
        idle(gap);
    endtask

    task automatic go(int ch);
        @(negedge clk); cmd_go_i = 1; cmd_chan_i = CW'(ch);
        @(negedge clk); cmd_go_i = 0;
    endtask

    task automatic ev(bit is_stop, bit with_rise);
        @(negedge clk);
        if (is_stop) stop_det_i = 1; else start_det_i = 1;
        scl_rise_i = with_rise; sda_lvl_i = 1;
        @(negedge clk); stop_det_i = 0; start_det_i = 0; scl_rise_i = 0;
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1", int'(mode_active_o), 0, "mode after reset");
        chk("R1", int'(wiper_o[3*W +: W]), 128, "wiper3 after reset");
        cur_req = "R5";
        rise(1, 1); rise(0, 1);
        chk("R5", int'(wiper_o[0 +: W]), 128, "idle rises ignored");
        cur_req = "R2"; go(1); idle(1);
        chk("R2", int'(mode_active_o), 1, "mode after go");
        cur_req = "R3"; for (int k = 0; k < 5; k++) rise(1, 1);
        cur_req = "R4"; for (int k = 0; k < 3; k++) rise(0, 2);
        idle(2);
        chk("R10", int'(wiper_o[1*W +: W]), 130, "ch1 after +5 -3");
        chk("R10", int'(wiper_o[2*W +: W]), 128, "ch2 untouched");
        cur_req = "R12";
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); scl_rise_i = 1; sda_lvl_i = (k % 3 != 0);
        end
        @(negedge clk); scl_rise_i = 0; idle(2);
        chk("R12", int'(wiper_o[1*W +: W]), 134, "ch1 after burst");
        cur_req = "R7"; ev(1, 0); rise(1, 1); rise(1, 1);
        chk("R7", int'(wiper_o[1*W +: W]), 134, "no step after stop");
        cur_req = "R8"; go(2); rise(1, 1); ev(0, 0); rise(0, 1); idle(1);
        chk("R8", int'(wiper_o[2*W +: W]), 129, "no step after start");
        cur_req = "R9"; go(3); ev(1, 1); idle(2);
        chk("R9", int'(wiper_o[3*W +: W]), 128, "rise with stop");
        cur_req = "R11"; go(0);
        @(negedge clk); cmd_go_i = 1; cmd_chan_i = 2'd3; scl_rise_i = 1; sda_lvl_i = 1;
        @(negedge clk); cmd_go_i = 0; scl_rise_i = 0;
        rise(0, 1); idle(2);
        chk("R11", int'(wiper_o[0 +: W]), 128, "old target unchanged");
        chk("R11", int'(wiper_o[3*W +: W]), 127, "new target stepped");
        cur_req = "R6"; go(0);
        @(negedge clk); scl_rise_i = 1; sda_lvl_i = 1;
        idle(140);
        @(negedge clk); scl_rise_i = 0; idle(2);
        chk("R6", int'(wiper_o[0 +: W]), 255, "top saturation");
        @(negedge clk); scl_rise_i = 1; sda_lvl_i = 0;
        idle(270);
        @(negedge clk); scl_rise_i = 0; idle(2);
        chk("R6", int'(wiper_o[0 +: W]), 0, "bottom saturation");
        ev(1, 0); idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule